// File: doc/BRIEF.md
# Auto-length three-wire tuning word receiver

This block receives synthesizer tuning words over a three-line serial link: a serial clock, a data line and an enable line. While enable is high, every rising edge of the serial clock shifts one data bit into a holding register and advances a bit counter. When enable drops, the counter value selects the word format (18, 19 or 27 bits). The block then loads that format's fields into its output registers. Words of any other length are thrown away.

The outputs drive a frequency synthesizer: the main divider ratio, the swallow counter ratio, four band-switch enables, a charge-pump current select, a charge-pump disable and a reference divider select. The two shorter formats carry no reference divider bits. For them the reference ratio follows a static strap input. All three serial lines and the strap are brought into the system clock domain through synchronizer flops, and edges are detected in that domain.

Top module: `serial_tune_rx`

## Requirements
- R1: A data bit is taken on each synchronized rising edge of `serClk` while `serEn` is high. Only the first 27 bits after enable rises are kept. Later bits are ignored, so a frame longer than 27 bits is loaded exactly like the 27-bit word formed by its first 27 bits.
- R2: Outputs change only when enable falls. While a frame is still being shifted in, every output keeps its previous value.
- R3: An 18-bit frame, in transmit order, carries the band enables (bit 3 first), then main divider bits 8 down to 0, then swallow bits 4 down to 0. Main divider bit 9 is cleared. `refSel` becomes 2'b00 (divide by 80) when `strapHigh` is 1, and 2'b11 (divide by 64) when it is 0.
- R4: A 19-bit frame, in transmit order, carries the band enables (bit 3 first), then main divider bits 9 down to 0, then swallow bits 4 down to 0. `refSel` becomes 2'b00 (divide by 80) when `strapHigh` is 1, and 2'b01 (divide by 128) when it is 0.
- R5: A 27-bit frame is laid out like a 19-bit frame and is followed by eight control bits. In transmit order these are: unused, pump current select, pump disable, unused, R1, R0, unused, unused. `refSel` becomes 2'b01 when R1:R0 is 01, 2'b11 when it is 11, and 2'b00 when R0 is 0.
- R6: 18-bit and 19-bit frames leave `cpHigh` and `cpOff` unchanged.
- R7: A frame whose bit count is neither 18 nor 19 nor at least 27 (this includes an enable pulse with no clocks) changes no output.
- R8: After reset every output is zero. This means `refSel` is 2'b00, all band outputs are off, and both divider ratios are zero.
- R9: A serial clock rise that is synchronized in the same cycle as the enable fall is not counted. A serial clock rise that is synchronized in the same cycle as the enable rise is counted as the first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial bit clock, asynchronous |
| serData | input | 1 | Serial data, asynchronous |
| serEn | input | 1 | Frame enable, high during a frame, asynchronous |
| strapHigh | input | 1 | Static strap level used by the short formats |
| bandSel | output | 4 | Band switch enables |
| mainDiv | output | 10 | Main divider ratio |
| swallowCnt | output | 5 | Swallow counter ratio |
| cpHigh | output | 1 | Charge pump high-current select |
| cpOff | output | 1 | Charge pump disable |
| refSel | output | 2 | Reference divider select: 00 /80, 01 /128, 11 /64 |

## Verification
Two pairs of events can land in the same synchronized cycle. In the first, the last clock rise coincides with the enable fall. In the second, the first clock rise coincides with the enable rise. The bench causes each one by changing both pins in the same drive step, so both pass through identical synchronizer depths. In the first case it expects the format of the shorter count (19 pulses load as an 18-bit word). In the second case it expects the coincident bit to be counted (19 pulses load as a 19-bit word).

// File: rtl/sertune_pkg.sv
`timescale 1ns/1ps
package sertune_pkg;

  localparam int BandW  = 4;
  localparam int MainW  = 10;
  localparam int SwalW  = 5;
  localparam int CtrlW  = 8;

  localparam int LenShort = BandW + MainW - 1 + SwalW;   // 18
  localparam int LenMid   = BandW + MainW + SwalW;       // 19
  localparam int LenLong  = LenMid + CtrlW;              // 27

  localparam logic [1:0] REF_DIV80  = 2'b00;
  localparam logic [1:0] REF_DIV128 = 2'b01;
  localparam logic [1:0] REF_DIV64  = 2'b11;

  typedef enum logic [1:0] {
    FMT_NONE = 2'd0,
    FMT_18   = 2'd1,
    FMT_19   = 2'd2,
    FMT_27   = 2'd3
  } frameFmt_e;

  typedef struct packed {
    logic      shiftEn;
    logic      bitIn;
    logic      commit;
    frameFmt_e fmt;
    logic      strapHigh;
  } dpStrobe_t;

endpackage

// File: rtl/sertune_ctrl.sv
`timescale 1ns/1ps
module sertune_ctrl
  import sertune_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      serClk,
  input  logic      serData,
  input  logic      serEn,
  input  logic      strapIn,
  output dpStrobe_t strobe
);

  localparam int CntW  = $clog2(LenLong + 1);
  localparam int LineN = 4;

  logic [LineN-1:0] rawIn;
  logic [SyncStages-1:0][LineN-1:0] syncStage;
  logic [LineN-1:0] syncd;
  logic syncClk, syncData, syncEn, syncStrap;
  logic clkPrev, enPrev;
  logic clkRise, enRise, enFall;
  logic [CntW-1:0] bitCnt, cntBase, cntNext;
  logic take;
  frameFmt_e fmtNow;

  assign rawIn = {strapIn, serEn, serData, serClk};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncStage <= '0;
    end else begin
      syncStage[0] <= rawIn;
      for (int i = 1; i < SyncStages; i++) begin
        syncStage[i] <= syncStage[i-1];
      end
    end
  end

  assign syncd     = syncStage[SyncStages-1];
  assign syncClk   = syncd[0];
  assign syncData  = syncd[1];
  assign syncEn    = syncd[2];
  assign syncStrap = syncd[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev <= 1'b0;
      enPrev  <= 1'b0;
    end else begin
      clkPrev <= syncClk;
      enPrev  <= syncEn;
    end
  end

  assign clkRise = syncClk & ~clkPrev;
  assign enRise  = syncEn & ~enPrev;
  assign enFall  = ~syncEn & enPrev;

  // a new frame restarts the count in the same cycle its first bit may arrive
  assign cntBase = enRise ? '0 : bitCnt;
  assign take    = clkRise & syncEn & (cntBase < CntW'(LenLong));
  assign cntNext = cntBase + CntW'(take);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else       bitCnt <= cntNext;
  end

  always_comb begin
    case (bitCnt)
      CntW'(LenShort): fmtNow = FMT_18;
      CntW'(LenMid):   fmtNow = FMT_19;
      CntW'(LenLong):  fmtNow = FMT_27;
      default:         fmtNow = FMT_NONE;
    endcase
  end

  always_comb begin
    strobe.shiftEn   = take;
    strobe.bitIn     = syncData;
    strobe.fmt       = fmtNow;
    strobe.commit    = enFall & (fmtNow != FMT_NONE);
    strobe.strapHigh = syncStrap;
  end

  a_r1_cnt_cap: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CntW'(LenLong));

  a_r1_cnt_step: assert property (@(posedge clk) disable iff (!rstN)
    (syncEn && !enRise) |=>
      (bitCnt == $past(bitCnt) || bitCnt == $past(bitCnt) + CntW'(1)));

  a_r9_no_take_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    enFall |=> bitCnt == $past(bitCnt));

endmodule

// File: rtl/sertune_dp.sv
`timescale 1ns/1ps
module sertune_dp
  import sertune_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  output logic [BandW-1:0] bandSel,
  output logic [MainW-1:0] mainDiv,
  output logic [SwalW-1:0] swallowCnt,
  output logic             cpHigh,
  output logic             cpOff,
  output logic [1:0]       refSel
);

  // field positions, counted from the last bit received (index 0)
  localparam int ShortBandLo = LenShort - BandW;
  localparam int MidBandLo   = LenMid - BandW;
  localparam int LongBandLo  = LenLong - BandW;
  localparam int LongMainLo  = CtrlW + SwalW;
  localparam int LongSwalLo  = CtrlW;
  localparam int PosCp = CtrlW - 2;
  localparam int PosCd = CtrlW - 3;
  localparam int PosR1 = CtrlW - 5;
  localparam int PosR0 = CtrlW - 6;

  logic [LenLong-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else if (strobe.shiftEn) shReg <= {shReg[LenLong-2:0], strobe.bitIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bandSel    <= '0;
      mainDiv    <= '0;
      swallowCnt <= '0;
      cpHigh     <= 1'b0;
      cpOff      <= 1'b0;
      refSel     <= REF_DIV80;
    end else if (strobe.commit) begin
      case (strobe.fmt)
        FMT_18: begin
          bandSel    <= shReg[ShortBandLo +: BandW];
          mainDiv    <= {1'b0, shReg[SwalW +: MainW-1]};
          swallowCnt <= shReg[0 +: SwalW];
          refSel     <= strobe.strapHigh ? REF_DIV80 : REF_DIV64;
        end
        FMT_19: begin
          bandSel    <= shReg[MidBandLo +: BandW];
          mainDiv    <= shReg[SwalW +: MainW];
          swallowCnt <= shReg[0 +: SwalW];
          refSel     <= strobe.strapHigh ? REF_DIV80 : REF_DIV128;
        end
        FMT_27: begin
          bandSel    <= shReg[LongBandLo +: BandW];
          mainDiv    <= shReg[LongMainLo +: MainW];
          swallowCnt <= shReg[LongSwalLo +: SwalW];
          cpHigh     <= shReg[PosCp];
          cpOff      <= shReg[PosCd];
          refSel     <= shReg[PosR0] ? {shReg[PosR1], 1'b1} : REF_DIV80;
        end
        default: ;
      endcase
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable({bandSel, mainDiv, swallowCnt, cpHigh, cpOff, refSel}));

  a_r3_m9_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && strobe.fmt == FMT_18) |=> !mainDiv[MainW-1]);

  a_r3_strap_ref: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && strobe.fmt != FMT_27 && strobe.strapHigh) |=> refSel == REF_DIV80);

  a_r6_keep_pump: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && strobe.fmt != FMT_27) |=> ($stable(cpHigh) && $stable(cpOff)));

  a_r5_no_code10: assert property (@(posedge clk) disable iff (!rstN)
    refSel != 2'b10);

endmodule

// File: rtl/serial_tune_rx.sv
`timescale 1ns/1ps
module serial_tune_rx
  import sertune_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClk,
  input  logic        serData,
  input  logic        serEn,
  input  logic        strapHigh,
  output logic [3:0]  bandSel,
  output logic [9:0]  mainDiv,
  output logic [4:0]  swallowCnt,
  output logic        cpHigh,
  output logic        cpOff,
  output logic [1:0]  refSel
);

  dpStrobe_t strobe;

  sertune_ctrl #(.SyncStages(SyncStages)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .serClk  (serClk),
    .serData (serData),
    .serEn   (serEn),
    .strapIn (strapHigh),
    .strobe  (strobe)
  );

  sertune_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .bandSel    (bandSel),
    .mainDiv    (mainDiv),
    .swallowCnt (swallowCnt),
    .cpHigh     (cpHigh),
    .cpOff      (cpOff),
    .refSel     (refSel)
  );

endmodule

// File: tb/serial_tune_rx_tb.sv
`timescale 1ns/1ps
module serial_tune_rx_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serEn = 1'b0, strapHigh = 1'b0;
  logic [3:0] bandSel;
  logic [9:0] mainDiv;
  logic [4:0] swallowCnt;
  logic cpHigh, cpOff;
  logic [1:0] refSel;

  int checks = 0;
  int fails  = 0;

  logic [3:0] expBand = '0;
  logic [9:0] expMain = '0;
  logic [4:0] expSwal = '0;
  logic expCp = 1'b0, expCd = 1'b0;
  logic [1:0] expRef = 2'b00;

  always #10 clk = ~clk;

  serial_tune_rx dut_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .serEn(serEn),
    .strapHigh(strapHigh), .bandSel(bandSel), .mainDiv(mainDiv),
    .swallowCnt(swallowCnt), .cpHigh(cpHigh), .cpOff(cpOff), .refSel(refSel)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseBit(input logic b);
    serData = b;
    tick(2);
    serClk = 1'b1;
    tick(2);
    serClk = 1'b0;
    tick(1);
  endtask

  task automatic sendFrame(input int len, input logic [29:0] w);
    serEn = 1'b1;
    tick(3);
    for (int i = len - 1; i >= 0; i--) pulseBit(w[i]);
    tick(1);
    serEn = 1'b0;
    tick(6);
  endtask

  // expected register update from the requirements
  task automatic model(input int len, input logic [29:0] w, input logic strap);
    logic [26:0] f;
    if (len == 18) begin
      expBand = w[17:14];
      expMain = {1'b0, w[13:5]};
      expSwal = w[4:0];
      expRef  = strap ? 2'b00 : 2'b11;
    end else if (len == 19) begin
      expBand = w[18:15];
      expMain = w[14:5];
      expSwal = w[4:0];
      expRef  = strap ? 2'b00 : 2'b01;
    end else if (len >= 27) begin
      f = 27'(w >> (len - 27));
      expBand = f[26:23];
      expMain = f[22:13];
      expSwal = f[12:8];
      expCp   = f[6];
      expCd   = f[5];
      expRef  = f[2] ? {f[3], 1'b1} : 2'b00;
    end
  endtask

  task automatic check(input string tag);
    checks++;
    if (bandSel !== expBand || mainDiv !== expMain || swallowCnt !== expSwal ||
        cpHigh !== expCp || cpOff !== expCd || refSel !== expRef) begin
      fails++;
      $display("FAIL %s: got band=%h main=%h swal=%h cp=%b cd=%b ref=%b, expected band=%h main=%h swal=%h cp=%b cd=%b ref=%b",
               tag, bandSel, mainDiv, swallowCnt, cpHigh, cpOff, refSel,
               expBand, expMain, expSwal, expCp, expCd, expRef);
    end
  endtask

  function automatic string tagFor(input int len);
    if (len == 18) return "R3";
    if (len == 19) return "R4";
    if (len == 27) return "R5";
    if (len > 27)  return "R1";
    return "R7";
  endfunction

  initial begin
    logic [29:0] w;
    tick(5);
    rstN = 1'b1;
    tick(3);
    check("R8");

    // sweep of every length with both strap levels and several patterns
    for (int s = 0; s < 2; s++) begin
      strapHigh = s[0];
      tick(3);
      for (int p = 0; p < 3; p++) begin
        for (int len = 0; len <= 30; len++) begin
          w = 30'(32'h9E3779B9 * (len + 1) + p * 32'h3C6EF372 + s * 32'h1234567);
          sendFrame(len, w);
          model(len, w, strapHigh);
          check(tagFor(len));
        end
      end
    end

    // all four reference codes in a long frame
    for (int r = 0; r < 4; r++) begin
      w = 30'(32'h2B7E1516 ^ (r * 32'h11111111));
      w[3:2] = r[1:0];
      sendFrame(27, w);
      model(27, w, strapHigh);
      check("R5");
    end

    // short frames keep pump bits: set them first
    w = 30'h0000_0060;
    sendFrame(27, w);
    model(27, w, strapHigh);
    check("R5");
    sendFrame(18, 30'h2AAAA);
    model(18, 30'h2AAAA, strapHigh);
    check("R6");
    sendFrame(19, 30'h15555);
    model(19, 30'h15555, strapHigh);
    check("R6");

    // outputs hold mid-frame
    w = 30'h5A3C7;
    serEn = 1'b1;
    tick(3);
    for (int i = 18; i >= 9; i--) pulseBit(w[i]);
    check("R2");
    for (int i = 8; i >= 0; i--) pulseBit(w[i]);
    tick(1);
    serEn = 1'b0;
    tick(6);
    model(19, w, strapHigh);
    check("R2");

    // last clock rise together with enable fall: not counted
    strapHigh = 1'b0;
    tick(3);
    w = 30'h6B2D9;
    serEn = 1'b1;
    tick(3);
    for (int i = 18; i >= 1; i--) pulseBit(w[i]);
    serData = w[0];
    tick(2);
    serClk = 1'b1;
    serEn  = 1'b0;
    tick(2);
    serClk = 1'b0;
    tick(6);
    model(18, w >> 1, strapHigh);
    check("R9");

    // first clock rise together with enable rise: counted
    w = 30'h3C4E1;
    serData = w[18];
    tick(2);
    serEn  = 1'b1;
    serClk = 1'b1;
    tick(2);
    serClk = 1'b0;
    tick(1);
    for (int i = 17; i >= 0; i--) pulseBit(w[i]);
    tick(1);
    serEn = 1'b0;
    tick(6);
    model(19, w, strapHigh);
    check("R9");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1: watchdog expired, got running, expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule